// File: doc/BRIEF.md
# Bus Parity Generator and Address-Error Signaller

This block handles even parity for a 32-bit multiplexed address/data bus and its four command/byte-enable lines. When the local agent sources the bus, the block computes the parity of all 36 lines and presents it one clock later, together with an output enable. When another agent sources the address, the block records the parity expected for the address phase. It compares that value with the parity line in the following clock.

A mismatch on an address phase raises a one-clock system-error pulse two clocks after that address phase. The pulse is raised only if both the parity-response enable and the system-error enable were set. The system-error output is an active-high pull-down enable for an open-drain line. The block never drives the line high; the external pull-up returns it to the idle level. A sticky flag records that a system error was signalled. It stays set until software clears it.

The parity check is skipped in three cases: data phases, cycles marked as turnaround, and transactions for which the local agent is the master.

Top module: `bus_parity_serr`

## Requirements
- R1: `par_oe_o` is high in a clock exactly when `drive_i` was high in the previous clock.
- R2: While `par_oe_o` is high, `par_o` makes the count of ones over it plus the previous clock's `ad_i` and `cbe_i` even, so `par_o` is the XOR of those 36 bits.
- R3: `par_o` is low whenever `par_oe_o` is low.
- R4: An address phase in clock t is in error when `par_i` in clock t+1 differs from the XOR of `ad_i` and `cbe_i` in clock t. Such an error makes `serr_oe_o` high for clock t+2 only.
- R5: A clock with `addr_phase_i` low never leads to a pulse on `serr_oe_o`, whatever the parity.
- R6: An address phase marked with `turnaround_i` high is not checked and produces no pulse.
- R7: The pulse is issued only if both `perr_resp_en_i` and `serr_en_i` were high during the address phase. If either enable was low, a bad address produces no pulse.
- R8: An address phase with `master_i` high is not checked and produces no pulse.
- R9: `serr_sticky_o` goes high in the same clock as a pulse and stays high until `sticky_clr_i` is seen high. It is then low from the next clock. A pulse in the clock after the clear request wins over the clear.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus as seen on the wires |
| cbe_i | input | 4 | Command/byte-enable lines as seen on the wires |
| par_i | input | 1 | Parity line as seen on the wire |
| drive_i | input | 1 | Local agent sources the address/data bus this clock |
| addr_phase_i | input | 1 | This clock is an address phase |
| turnaround_i | input | 1 | This clock is a bus turnaround |
| master_i | input | 1 | Local agent is master of the current transaction |
| perr_resp_en_i | input | 1 | Parity-error response enable |
| serr_en_i | input | 1 | System-error enable |
| sticky_clr_i | input | 1 | Clear request for the sticky flag |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity bit |
| serr_oe_o | output | 1 | Pull-down enable for the system-error line |
| serr_sticky_o | output | 1 | Sticky flag: a system error was signalled |

## Verification
The bound checker checks the following on every clock:
- the one-clock lag of the parity output enable, the even parity value and the quiet parity line;
- that every system-error pulse has an address phase two clocks earlier, with both enables set, no master or turnaround flag, and a real parity mismatch;
- that the sticky flag rises only with a pulse.

Only the directed scenarios show the converse: that a bad address phase actually produces the pulse in exactly the right clock and for one clock only. The same holds for the clear timing of the sticky flag and for set winning over clear.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   // Snapshot taken in an address phase, consumed one clock later.
   typedef struct packed {
      logic armed;      // phase is checkable and reporting is enabled
      logic expect_par; // parity the source must present next clock
   } addr_snap_t;

   localparam addr_snap_t SNAP_IDLE = '{armed: 1'b0, expect_par: 1'b0};

endpackage

// File: rtl/bpar_xor_tree.sv
module bpar_xor_tree #(
   parameter int N = 36
) (
   input  logic [N-1:0] bits_i,
   output logic         par_o
);
   localparam int LVLS = (N <= 1) ? 1 : $clog2(N);
   localparam int NP   = 1 << LVLS;

   if (N < 1) begin : g_bad_n
      $error("bpar_xor_tree: N must be at least 1");
   end

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      localparam int W = NP >> l;
      logic [W-1:0] v;
      if (l == 0) begin : g_leaf
         assign v = W'(bits_i);
      end else begin : g_node
         for (genvar i = 0; i < W; i++) begin : g_x
            assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
         end
      end
   end

   assign par_o = g_lvl[LVLS].v[0];
endmodule

// File: rtl/bpar_drive.sv
module bpar_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic drive_i,
   input  logic par_calc_i,
   output logic par_o,
   output logic par_oe_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_oe_o <= 1'b0;
         par_o    <= 1'b0;
      end else begin
         par_oe_o <= drive_i;
         par_o    <= drive_i & par_calc_i;
      end
   end
endmodule

// File: rtl/bpar_addr_chk.sv
module bpar_addr_chk
   import bpar_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic addr_phase_i,
   input  logic turnaround_i,
   input  logic master_i,
   input  logic perr_resp_en_i,
   input  logic serr_en_i,
   input  logic par_calc_i,
   input  logic par_i,
   output logic err_hit_o
);
   addr_snap_t snap_q, snap_d;

   always_comb begin
      snap_d            = SNAP_IDLE;
      snap_d.armed      = addr_phase_i & ~turnaround_i & ~master_i
                          & perr_resp_en_i & serr_en_i;
      snap_d.expect_par = par_calc_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q <= SNAP_IDLE;
      else        snap_q <= snap_d;
   end

   assign err_hit_o = snap_q.armed & (par_i ^ snap_q.expect_par);
endmodule

// File: rtl/bpar_serr.sv
module bpar_serr (
   input  logic clk,
   input  logic rst_n,
   input  logic err_hit_i,
   input  logic sticky_clr_i,
   output logic serr_oe_o,
   output logic serr_sticky_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serr_oe_o     <= 1'b0;
         serr_sticky_o <= 1'b0;
      end else begin
         serr_oe_o <= err_hit_i;
         if (err_hit_i)         serr_sticky_o <= 1'b1;
         else if (sticky_clr_i) serr_sticky_o <= 1'b0;
      end
   end
endmodule

// File: rtl/bus_parity_serr.sv
module bus_parity_serr #(
   parameter int AD_W  = 32,
   parameter int CBE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AD_W-1:0]  ad_i,
   input  logic [CBE_W-1:0] cbe_i,
   input  logic             par_i,
   input  logic             drive_i,
   input  logic             addr_phase_i,
   input  logic             turnaround_i,
   input  logic             master_i,
   input  logic             perr_resp_en_i,
   input  logic             serr_en_i,
   input  logic             sticky_clr_i,
   output logic             par_o,
   output logic             par_oe_o,
   output logic             serr_oe_o,
   output logic             serr_sticky_o
);
   localparam int COVER_W = AD_W + CBE_W;

   if (CBE_W < 1 || AD_W != 8 * CBE_W) begin : g_bad_w
      $error("bus_parity_serr: AD_W must be 8 lanes per CBE_W line");
   end

   logic par_calc;
   logic err_hit;

   bpar_xor_tree #(.N(COVER_W)) u_tree (
      .bits_i ({ad_i, cbe_i}),
      .par_o  (par_calc)
   );

   bpar_drive u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .drive_i    (drive_i),
      .par_calc_i (par_calc),
      .par_o      (par_o),
      .par_oe_o   (par_oe_o)
   );

   bpar_addr_chk u_chk (
      .clk            (clk),
      .rst_n          (rst_n),
      .addr_phase_i   (addr_phase_i),
      .turnaround_i   (turnaround_i),
      .master_i       (master_i),
      .perr_resp_en_i (perr_resp_en_i),
      .serr_en_i      (serr_en_i),
      .par_calc_i     (par_calc),
      .par_i          (par_i),
      .err_hit_o      (err_hit)
   );

   bpar_serr u_serr (
      .clk           (clk),
      .rst_n         (rst_n),
      .err_hit_i     (err_hit),
      .sticky_clr_i  (sticky_clr_i),
      .serr_oe_o     (serr_oe_o),
      .serr_sticky_o (serr_sticky_o)
   );
endmodule

// File: rtl/bpar_sva.sv
module bpar_sva #(
   parameter int AD_W  = 32,
   parameter int CBE_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AD_W-1:0]  ad_i,
   input logic [CBE_W-1:0] cbe_i,
   input logic             par_i,
   input logic             drive_i,
   input logic             addr_phase_i,
   input logic             turnaround_i,
   input logic             master_i,
   input logic             perr_resp_en_i,
   input logic             serr_en_i,
   input logic             par_o,
   input logic             par_oe_o,
   input logic             serr_oe_o,
   input logic             serr_sticky_o
);
   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1) |-> (par_oe_o == $past(drive_i)));                        // R1
   AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && par_oe_o) |-> (par_o == ^{$past(ad_i), $past(cbe_i)})); // R2
   AST_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !par_oe_o |-> !par_o);                                                  // R3
   AST_SERR_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> (cyc >= 2'd2 &&
                     $past(par_i) != ^{$past(ad_i, 2), $past(cbe_i, 2)}));    // R4
   AST_SERR_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> (cyc >= 2'd2 && $past(addr_phase_i, 2)));                 // R5
   AST_SERR_NO_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> (cyc >= 2'd2 && !$past(turnaround_i, 2)));                // R6
   AST_SERR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> (cyc >= 2'd2 && $past(perr_resp_en_i, 2)
                     && $past(serr_en_i, 2)));                                // R7
   AST_SERR_NOT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> (cyc >= 2'd2 && !$past(master_i, 2)));                    // R8
   AST_STICKY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> serr_sticky_o);                                           // R9
   AST_STICKY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serr_sticky_o) |-> serr_oe_o);                                    // R9
endmodule

bind bus_parity_serr bpar_sva #(.AD_W(AD_W), .CBE_W(CBE_W)) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .ad_i           (ad_i),
   .cbe_i          (cbe_i),
   .par_i          (par_i),
   .drive_i        (drive_i),
   .addr_phase_i   (addr_phase_i),
   .turnaround_i   (turnaround_i),
   .master_i       (master_i),
   .perr_resp_en_i (perr_resp_en_i),
   .serr_en_i      (serr_en_i),
   .par_o          (par_o),
   .par_oe_o       (par_oe_o),
   .serr_oe_o      (serr_oe_o),
   .serr_sticky_o  (serr_sticky_o)
);

// File: tb/bus_parity_serr_tb_top.sv
`timescale 1ns/1ps
module bus_parity_serr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad_i = '0;
   logic [3:0]  cbe_i = '0;
   logic        par_i = 1'b0;
   logic        drive_i = 1'b0;
   logic        addr_phase_i = 1'b0;
   logic        turnaround_i = 1'b0;
   logic        master_i = 1'b0;
   logic        perr_resp_en_i = 1'b1;
   logic        serr_en_i = 1'b1;
   logic        sticky_clr_i = 1'b0;
   logic        par_o, par_oe_o, serr_oe_o, serr_sticky_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bus_parity_serr dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ad_i           (ad_i),
      .cbe_i          (cbe_i),
      .par_i          (par_i),
      .drive_i        (drive_i),
      .addr_phase_i   (addr_phase_i),
      .turnaround_i   (turnaround_i),
      .master_i       (master_i),
      .perr_resp_en_i (perr_resp_en_i),
      .serr_en_i      (serr_en_i),
      .sticky_clr_i   (sticky_clr_i),
      .par_o          (par_o),
      .par_oe_o       (par_oe_o),
      .serr_oe_o      (serr_oe_o),
      .serr_sticky_o  (serr_sticky_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] got,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic epar(input logic [31:0] a, input logic [3:0] c);
      logic p = 1'b0;
      for (int i = 0; i < 32; i++) p ^= a[i];
      for (int i = 0; i < 4; i++)  p ^= c[i];
      return p;
   endfunction

   // R10: outputs quiet during reset
   task automatic t_reset();
      rst_n = 1'b0;
      drive_i = 1'b1;
      repeat (2) @(negedge clk);
      chk(par_oe_o == 0 && par_o == 0, "R10 parity outputs", {par_oe_o, par_o}, 0);
      chk(serr_oe_o == 0 && serr_sticky_o == 0, "R10 serr outputs",
          {serr_oe_o, serr_sticky_o}, 0);
      drive_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R1 R2 R3: back-to-back driven words, then release
   task automatic t_drive();
      logic [31:0] a [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'hA5C3_1E77};
      logic [3:0]  c [4] = '{4'h0, 4'hF, 4'h7, 4'h1};
      for (int k = 0; k < 4; k++) begin
         drive_i = 1'b1; ad_i = a[k]; cbe_i = c[k];
         @(negedge clk);
         chk(par_oe_o == 1'b1, "R1 oe after drive", par_oe_o, 1);
         chk(par_o == epar(a[k], c[k]), "R2 even parity", par_o, epar(a[k], c[k]));
      end
      drive_i = 1'b0; ad_i = 32'hFFFF_FFFE; cbe_i = 4'h0;
      @(negedge clk);
      chk(par_oe_o == 1'b0, "R1 oe drops", par_oe_o, 0);
      chk(par_o == 1'b0, "R3 quiet parity", par_o, 0);
   endtask

   // Generic address phase scenario; R4 timing plus the suppression cases
   task automatic t_addr(input logic [31:0] a, input logic [3:0] c, input bit bad,
                         input bit aph, input bit ta, input bit mst, input bit pe,
                         input bit se, input bit clr, input bit exp, input string req);
      ad_i = a; cbe_i = c; addr_phase_i = aph; turnaround_i = ta;
      master_i = mst; perr_resp_en_i = pe; serr_en_i = se;
      @(negedge clk);
      chk(serr_oe_o == 1'b0, {req, " no early pulse"}, serr_oe_o, 0);
      addr_phase_i = 1'b0; turnaround_i = 1'b0; master_i = 1'b0;
      perr_resp_en_i = 1'b1; serr_en_i = 1'b1;
      par_i = epar(a, c) ^ bad;
      ad_i = ~a; cbe_i = c;
      sticky_clr_i = clr;
      @(negedge clk);
      chk(serr_oe_o == exp, {req, " pulse at t+2"}, serr_oe_o, exp);
      if (exp) chk(serr_sticky_o == 1'b1, "R9 sticky with pulse", serr_sticky_o, 1);
      par_i = epar(~a, c); sticky_clr_i = 1'b0;
      @(negedge clk);
      chk(serr_oe_o == 1'b0, {req, " single clock"}, serr_oe_o, 0);
      par_i = 1'b0;
   endtask

   // R9: hold and clear of the sticky flag
   task automatic t_sticky_clear();
      repeat (3) @(negedge clk);
      chk(serr_sticky_o == 1'b1, "R9 sticky holds", serr_sticky_o, 1);
      sticky_clr_i = 1'b1;
      @(negedge clk);
      sticky_clr_i = 1'b0;
      chk(serr_sticky_o == 1'b0, "R9 sticky cleared", serr_sticky_o, 0);
   endtask

   // R9: sticky stays clear when no pulse arrives
   task automatic t_sticky_low();
      @(negedge clk);
      chk(serr_sticky_o == 1'b0, "R9 sticky stays low", serr_sticky_o, 0);
   endtask

   initial begin
      t_reset();
      t_drive();
      t_addr(32'h1234_5678, 4'h6, 0, 1, 0, 0, 1, 1, 0, 0, "R4 good address");
      t_sticky_low();
      t_addr(32'h1234_5678, 4'h6, 1, 1, 0, 0, 1, 1, 0, 1, "R4 bad address");
      t_sticky_clear();
      t_addr(32'hDEAD_BEEF, 4'hA, 1, 0, 0, 0, 1, 1, 0, 0, "R5 data phase");
      t_addr(32'hDEAD_BEEF, 4'hA, 1, 1, 1, 0, 1, 1, 0, 0, "R6 turnaround");
      t_addr(32'h0F0F_0F0F, 4'h3, 1, 1, 0, 0, 0, 1, 0, 0, "R7 perr disabled");
      t_addr(32'h0F0F_0F0F, 4'h3, 1, 1, 0, 0, 1, 0, 0, 0, "R7 serr disabled");
      t_addr(32'h0F0F_0F0F, 4'h3, 1, 1, 0, 1, 1, 1, 0, 0, "R8 master");
      t_sticky_low();
      t_addr(32'hFFFF_FFFF, 4'hF, 1, 1, 0, 0, 1, 1, 1, 1, "R9 set over clear");
      t_sticky_clear();
      t_addr(32'h0000_0000, 4'h0, 1, 1, 0, 0, 1, 1, 0, 1, "R4 bad zero address");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule